// File: doc/BRIEF.md
# Clock Halt and Restart Controller

This block decides when a processor's generated clocks may run. On every rising edge of the generated CPU clock it samples a three-bit processor status. A two-step status sequence halts the clocks: an idle code, then a halt code on the next rising edge. The clock divider is outside the block and receives a run enable from it. It also receives a speed-mode select that is frozen while the clocks are stopped, so the divider resumes at the speed it had when it stopped.

The clock source is chosen by a mode input. In crystal mode a halt also switches the oscillator off. Restart then waits for a fixed number of cycles of the returning oscillator clock, so the oscillator has time to settle. In external-source mode the reference keeps running through a halt, and restart needs only a short count of external-source cycles.

A restart is requested by a rising edge on an asynchronous start input, or by the active-low reset-in level. The block also stretches the reset-in into an active-high reset-out. That output stays high for a minimum number of CPU clock rising edges after reset-in is released.

Top module: `clkhalt_ctrl`

## Requirements
- R1: While the synchronous reset `rst` is high and on the cycle after it falls, `clk_gate` is 1, `osc_en` is 1, `clk_slow` is 0 and `reset_out` is 1.
- R2: `status` is read as {s2,s1,s0}, and only in cycles where `cpu_rise` is 1 and the clocks run. If the code 3'b011 is read and the previous read was 3'b111, `clk_gate` is 0 from the cycle after that edge.
- R3: A 3'b011 read whose previous read was not 3'b111 does not halt. Once halted, `clk_gate` stays 0 until a restart trigger (R5 or R6) occurs.
- R4: When a halt occurs with `xtal_mode`=1, `osc_en` goes to 0 and stays 0 until a restart trigger. With `xtal_mode`=0, `osc_en` stays 1 throughout.
- R5: `start_in` passes through a two-flop synchronizer. Its rising edge restarts a halted controller. While the synchronized level is 1, a halt sequence is ignored.
- R6: `res_n` low while halted restarts the controller, exactly as a start edge does.
- R7: In crystal mode `osc_en` returns to 1 on restart. `clk_gate` returns to 1 in the cycle after the SETTLE_CYC-th (default 8192) `osc_tick` counted from the restart. The count starts from zero on every restart.
- R8: In external-source mode `clk_gate` returns to 1 in the cycle after the EXT_DELAY-th (default 3) `ext_tick` counted from the restart.
- R9: `clk_slow` takes `slow_req` on each edge while the clocks run. It keeps its value from the halt edge until the clocks run again.
- R10: `reset_out` is 1 whenever `res_n` is 0. After `res_n` rises, it stays 1 until RST_MIN (default 16) `cpu_rise` strobes have occurred with the clocks running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast reference clock of the control logic |
| rst | input | 1 | Synchronous active-high reset |
| xtal_mode | input | 1 | 1: crystal source, 0: external source |
| cpu_rise | input | 1 | One-cycle strobe marking a rising edge of the generated CPU clock |
| status | input | 3 | Processor status {s2,s1,s0} |
| start_in | input | 1 | Asynchronous restart request, rising edge active |
| res_n | input | 1 | Active-low reset-in, also a restart trigger |
| osc_tick | input | 1 | One-cycle strobe per returning oscillator cycle |
| ext_tick | input | 1 | One-cycle strobe per external-source cycle |
| slow_req | input | 1 | Requested speed mode (1 = slow) |
| clk_gate | output | 1 | 1 while generated clocks may run |
| osc_en | output | 1 | Oscillator enable |
| clk_slow | output | 1 | Speed mode handed to the divider, frozen while halted |
| reset_out | output | 1 | Active-high conditioned reset |

## Verification
The assertions assume that `xtal_mode` changes only while the clocks run. They also assume that `status` is stable around each `cpu_rise` strobe and that `osc_tick` and `ext_tick` are single-cycle strobes. The stimulus holds each status code for longer than one CPU clock period and never switches the source mode during a halt or a restart. It keeps `start_in` pulses longer than the synchronizer depth.

// File: rtl/clkhalt_pkg.sv
package clkhalt_pkg;

    typedef enum logic [1:0] {
        ST_RUN     = 2'd0,
        ST_HALT    = 2'd1,
        ST_SETTLE  = 2'd2,
        ST_EXTWAIT = 2'd3
    } ctl_state_t;

    localparam logic [2:0] STAT_IDLE = 3'b111;
    localparam logic [2:0] STAT_STOP = 3'b011;

    typedef struct packed {
        logic rise;
        logic level;
    } start_evt_t;

    function automatic logic code_is(input logic [2:0] s, input logic [2:0] code);
        return s == code;
    endfunction

endpackage

// File: rtl/clkhalt_start_edge.sv
module clkhalt_start_edge
    import clkhalt_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       start_in,
    output start_evt_t evt
);
    logic meta_q, sync_q, prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= 1'b0;
            sync_q <= 1'b0;
            prev_q <= 1'b0;
        end else begin
            meta_q <= start_in;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    assign evt.rise  = sync_q & ~prev_q;
    assign evt.level = sync_q;

    // R5
    single_rise_chk: assert property (@(posedge clk) disable iff (rst)
        evt.rise |=> !evt.rise);
endmodule

// File: rtl/clkhalt_stop_decode.sv
module clkhalt_stop_decode
    import clkhalt_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       strobe,
    input  logic       run,
    input  logic [2:0] status,
    input  logic       block,
    output logic       stop_hit
);
    logic idle_seen_q;

    always_ff @(posedge clk) begin
        if (rst || !run)
            idle_seen_q <= 1'b0;
        else if (strobe)
            idle_seen_q <= code_is(status, STAT_IDLE);
    end

    assign stop_hit = strobe & run & idle_seen_q & ~block & code_is(status, STAT_STOP);

    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (run && !strobe) |=> $stable(idle_seen_q));
endmodule

// File: rtl/clkhalt_restart_timer.sv
module clkhalt_restart_timer #(
    parameter int CNT_W = 14
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             tick,
    input  logic [CNT_W-1:0] limit,
    output logic             done
);
    logic [CNT_W-1:0] cnt_q;

    assign done = en & tick & (cnt_q == limit - 1'b1);

    always_ff @(posedge clk) begin
        if (rst || !en)
            cnt_q <= '0;
        else if (tick)
            cnt_q <= done ? '0 : cnt_q + 1'b1;
    end

    // R7
    cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
        en |-> (cnt_q < limit));
    // R8
    idle_clear_chk: assert property (@(posedge clk) disable iff (rst)
        !en |=> (cnt_q == '0));
endmodule

// File: rtl/clkhalt_reset_stretch.sv
module clkhalt_reset_stretch #(
    parameter int RST_MIN = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic res_n,
    input  logic strobe,
    input  logic run,
    output logic reset_out
);
    localparam int RW = $clog2(RST_MIN + 1);
    localparam logic [RW-1:0] LIMIT = RW'(RST_MIN);

    logic [RW-1:0] seen_q;

    always_ff @(posedge clk) begin
        if (rst || !res_n)
            seen_q <= '0;
        else if (strobe && run && (seen_q < LIMIT))
            seen_q <= seen_q + 1'b1;
    end

    assign reset_out = ~res_n | (seen_q < LIMIT);

    // R10
    release_high_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(res_n) |-> reset_out);
endmodule

// File: rtl/clkhalt_ctrl.sv
module clkhalt_ctrl
    import clkhalt_pkg::*;
#(
    parameter int SETTLE_CYC = 8192,
    parameter int EXT_DELAY  = 3,
    parameter int RST_MIN    = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       xtal_mode,
    input  logic       cpu_rise,
    input  logic [2:0] status,
    input  logic       start_in,
    input  logic       res_n,
    input  logic       osc_tick,
    input  logic       ext_tick,
    input  logic       slow_req,
    output logic       clk_gate,
    output logic       osc_en,
    output logic       clk_slow,
    output logic       reset_out
);
    localparam int CNT_W = $clog2(SETTLE_CYC + 1);
    localparam logic [CNT_W-1:0] LIM_XTAL = CNT_W'(SETTLE_CYC);
    localparam logic [CNT_W-1:0] LIM_EXT  = CNT_W'(EXT_DELAY);

    ctl_state_t state_q, state_d;
    start_evt_t sev;
    logic       stop_hit, run, waiting, tick_sel, timer_done, slow_q;
    logic [CNT_W-1:0] limit;

    assign run      = (state_q == ST_RUN);
    assign waiting  = (state_q == ST_SETTLE) || (state_q == ST_EXTWAIT);
    assign tick_sel = (state_q == ST_SETTLE) ? osc_tick : ext_tick;
    assign limit    = (state_q == ST_SETTLE) ? LIM_XTAL : LIM_EXT;

    clkhalt_start_edge u_start (
        .clk(clk), .rst(rst), .start_in(start_in), .evt(sev)
    );

    clkhalt_stop_decode u_decode (
        .clk(clk), .rst(rst), .strobe(cpu_rise), .run(run),
        .status(status), .block(sev.level), .stop_hit(stop_hit)
    );

    clkhalt_restart_timer #(.CNT_W(CNT_W)) u_timer (
        .clk(clk), .rst(rst), .en(waiting), .tick(tick_sel),
        .limit(limit), .done(timer_done)
    );

    clkhalt_reset_stretch #(.RST_MIN(RST_MIN)) u_rstout (
        .clk(clk), .rst(rst), .res_n(res_n), .strobe(cpu_rise),
        .run(run), .reset_out(reset_out)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN:     if (stop_hit) state_d = ST_HALT;
            ST_HALT:    if (sev.rise || !res_n)
                            state_d = xtal_mode ? ST_SETTLE : ST_EXTWAIT;
            ST_SETTLE,
            ST_EXTWAIT: if (timer_done) state_d = ST_RUN;
            default:    state_d = ST_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_RUN;
            slow_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            if (run) slow_q <= slow_req;
        end
    end

    assign clk_gate = run;
    assign osc_en   = !(xtal_mode && state_q == ST_HALT);
    assign clk_slow = slow_q;

    // R2
    stop_gate_chk: assert property (@(posedge clk) disable iff (rst)
        stop_hit |=> !clk_gate);
    // R3
    halt_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_HALT && res_n && !sev.rise) |=> !clk_gate);
    // R4
    osc_off_chk: assert property (@(posedge clk) disable iff (rst)
        (stop_hit && xtal_mode) |=> !osc_en);
    // R9
    speed_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !clk_gate |=> $stable(clk_slow));
endmodule

// File: tb/clkhalt_ctrl_bench.sv
module clkhalt_ctrl_bench;
    localparam int SETTLE = 8192;
    localparam int EXTD   = 3;
    localparam int RMIN   = 16;

    logic clk = 1'b0, rst = 1'b1;
    logic xtal_mode = 1'b0, cpu_rise = 1'b0, start_in = 1'b0, res_n = 1'b1;
    logic osc_tick = 1'b0, ext_tick = 1'b0, slow_req = 1'b0;
    logic [2:0] status = 3'b100;
    logic clk_gate, osc_en, clk_slow, reset_out;

    int checks = 0, failures = 0, cyc = 0, phase = 0;
    bit done = 0;

    always #10 clk = ~clk;

    clkhalt_ctrl #(.SETTLE_CYC(SETTLE), .EXT_DELAY(EXTD), .RST_MIN(RMIN)) u_clkhalt_ctrl (
        .clk(clk), .rst(rst), .xtal_mode(xtal_mode), .cpu_rise(cpu_rise),
        .status(status), .start_in(start_in), .res_n(res_n),
        .osc_tick(osc_tick), .ext_tick(ext_tick), .slow_req(slow_req),
        .clk_gate(clk_gate), .osc_en(osc_en), .clk_slow(clk_slow),
        .reset_out(reset_out)
    );

    // stimulus strobes, changed away from the active edge
    always @(negedge clk) begin
        phase    <= phase + 1;
        cpu_rise <= (phase % 3) == 0;
        osc_tick <= (phase % 2) == 0;
        ext_tick <= (phase % 4) == 0;
    end

    // behavioural reference model: 0 run, 1 halted, 2 crystal wait, 3 external wait
    int m_state = 0, m_cnt = 0, m_rc = 0;
    bit m_idle = 0, m_slow = 0;
    bit sh[3] = '{0, 0, 0};
    always @(posedge clk) begin
        bit rise, lvl;
        rise = sh[1] && !sh[2];
        lvl  = sh[1];
        if (rst) begin
            m_state = 0; m_cnt = 0; m_rc = 0; m_idle = 0; m_slow = 0;
            sh = '{0, 0, 0};
        end else begin
            if (!res_n) m_rc = 0;
            else if (cpu_rise && m_state == 0 && m_rc < RMIN) m_rc++;
            case (m_state)
                0: begin
                    m_slow = slow_req;
                    if (cpu_rise) begin
                        if (status == 3'b011 && m_idle && !lvl) m_state = 1;
                        m_idle = (status == 3'b111) && (m_state == 0);
                    end
                end
                1: if (rise || !res_n) begin m_state = xtal_mode ? 2 : 3; m_cnt = 0; end
                2: if (osc_tick) begin
                    m_cnt++;
                    if (m_cnt == SETTLE) begin m_state = 0; m_cnt = 0; end
                end
                default: if (ext_tick) begin
                    m_cnt++;
                    if (m_cnt == EXTD) begin m_state = 0; m_cnt = 0; end
                end
            endcase
            sh[2] = sh[1]; sh[1] = sh[0]; sh[0] = start_in;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cyc);
        end
    endtask

    always @(negedge clk) begin
        cyc <= cyc + 1;
        if (!done) begin
            chk("R2 clk_gate model", clk_gate, m_state == 0);
            chk("R4 osc_en model", osc_en, !(xtal_mode && m_state == 1));
            chk("R9 clk_slow model", clk_slow, m_slow);
            chk("R10 reset_out model", reset_out, (!res_n) || (m_rc < RMIN));
        end
    end

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic issue_stop();
        status = 3'b111; cycles(4);
        status = 3'b011; cycles(4);
        status = 3'b100; cycles(1);
    endtask

    task automatic pulse_start();
        start_in = 1'b1; cycles(6);
        start_in = 1'b0;
    endtask

    task automatic wait_run(output int n);
        n = 0;
        while (!clk_gate && n < 40000) begin @(negedge clk); n++; end
    endtask

    initial begin
        int n;
        cycles(3);
        chk("R1 gate in reset", clk_gate, 1);
        chk("R1 osc in reset", osc_en, 1);
        chk("R1 reset_out in reset", reset_out, 1);
        rst = 1'b0;
        cycles(1);
        chk("R1 gate after reset", clk_gate, 1);
        chk("R10 reset_out held", reset_out, 1);
        cycles(60);
        chk("R10 reset_out released", reset_out, 0);

        // r3_ halt code without idle before it
        status = 3'b101; cycles(4);
        status = 3'b011; cycles(4);
        status = 3'b100; cycles(1);
        chk("R3 no halt without idle", clk_gate, 1);

        // external-source halt and restart
        issue_stop();
        chk("R2 halted", clk_gate, 0);
        chk("R4 osc kept in ext mode", osc_en, 1);
        slow_req = 1'b1; cycles(30);
        chk("R3 stays halted", clk_gate, 0);
        chk("R9 speed frozen", clk_slow, 0);
        pulse_start();
        wait_run(n);
        chk("R8 ext restart happened", clk_gate, 1);
        chk("R8 ext restart short", (n <= 20) ? 1 : 0, 1);
        cycles(2);
        chk("R9 speed follows when running", clk_slow, 1);

        // start high blocks halt
        start_in = 1'b1; cycles(4);
        issue_stop();
        chk("R5 start level blocks halt", clk_gate, 1);
        start_in = 1'b0; cycles(4);

        // crystal halt and long restart
        xtal_mode = 1'b1; cycles(2);
        issue_stop();
        chk("R2 halted crystal", clk_gate, 0);
        chk("R4 osc off in crystal halt", osc_en, 0);
        pulse_start();
        cycles(2000);
        chk("R7 still settling", clk_gate, 0);
        chk("R7 osc back on", osc_en, 1);
        wait_run(n);
        chk("R7 crystal restart happened", clk_gate, 1);
        chk("R7 settle length", (n >= 2*SETTLE - 2010 && n <= 2*SETTLE - 1980) ? 1 : 0, 1);

        // res_n low restarts a halted controller
        xtal_mode = 1'b0; cycles(2);
        issue_stop();
        chk("R6 halted before res_n", clk_gate, 0);
        res_n = 1'b0; cycles(1);
        chk("R10 reset_out with res_n low", reset_out, 1);
        wait_run(n);
        chk("R6 res_n restart", clk_gate, 1);
        cycles(10);
        res_n = 1'b1; cycles(1);
        chk("R10 reset_out after release", reset_out, 1);
        cycles(3 * RMIN - 6);
        chk("R10 reset_out before minimum", reset_out, 1);
        cycles(20);
        chk("R10 reset_out after minimum", reset_out, 0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(20 * 150000);
        failures++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule